// File: doc/BRIEF.md
# Flash Command Interface Model

This block is a clocked behavioural model of the command front end of a byte-wide electrically erasable memory. A host drives an asynchronous-style bus made of an active-low chip select, an active-low output enable, an active-low write enable, an address and a byte of data. The block samples every bus pin with the system clock. Commands and operands are captured from write-enable edges. A decoder then moves the device between array read, identifier read, program and erase set-up, and the two verify modes.

Program and erase act on a small parameterised byte array. Each operation holds a busy flag for a fixed number of clock cycles, and during that time further writes are dropped. All writes are dropped while the programming-voltage flag is low. The data bus is driven only during a selected, output-enabled read. The bidirectional pad is split into a data output and a drive-enable output.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset every array byte reads 0xFF, the read mode is array read, busy_o is low and data_oe_o is low while chip select is high.
- R2: data_oe_o is high exactly when cs_ni and oe_ni are both low. With cs_ni high it is low whatever oe_ni does.
- R3: A write cycle takes its address from addr_i at the clock where we_ni is first seen low while cs_ni is low. It takes its data from data_i at the clock where we_ni is first seen high again. Changes in between have no effect.
- R4: In array-read mode (entered by 0x00), data_o returns the stored byte at addr_i.
- R5: Writing 0x90 enters identifier mode. A read with addr_i[0]=0 returns 0x89, and a read with addr_i[0]=1 returns 0xBD.
- R6: Writing 0xFF returns the block to array-read mode from any mode that decodes commands.
- R7: A written value other than 0xFF or 0x90 whose bits 4..0 are not all zero is rejected, and the mode is left unchanged. A value whose bits 7..5 are 011, 100 or 111 is also rejected.
- R8: Writing 0x40 arms a program. The next accepted write ANDs its data into the byte at its address. busy_o then stays high for exactly BUSY_CYC cycles, independent of cs_ni, and the mode returns to array read.
- R9: Writing 0x20 arms an erase. A following write of 0x20 sets every byte to 0xFF and raises busy_o for BUSY_CYC cycles. Any other following value cancels the erase and leaves the array unchanged. In both cases the mode returns to array read.
- R10: Writes completed while busy_o is high have no effect.
- R11: While vpp_hi_i is low, every write is ignored. Reads still work.
- R12: Writing 0xC0 (program verify) or 0xA0 (erase verify) makes reads return the byte at the address latched with that command, whatever addr_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all bus pins are sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Byte address |
| data_i | input | 8 | Data written by the host |
| vpp_hi_i | input | 1 | Programming voltage present; writes honoured only when high |
| data_o | output | 8 | Read data, meaningful when data_oe_o is high |
| data_oe_o | output | 1 | Drive enable for the data pad; low means high impedance |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The command path is exercised with valid codes, with codes whose low bits are dirty, with unassigned top-bit codes, with writes made while the programming voltage is absent, and with writes made during busy. Each of the dropped writes uses a code whose effect would show at the data port: identifier entry changes the byte read at address 0, and a program changes a known byte. This separates "rejected" from "accepted but harmless". Program writes move the address and the data between the write-enable edges, so a capture on the wrong edge stores the wrong byte at the wrong location. Verify reads use an address that differs from the latched one, and erase is tried both confirmed and cancelled.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    MODE_ARRAY, MODE_IDENT, MODE_PGM_ARM, MODE_ERS_ARM, MODE_PGM_CHK, MODE_ERS_CHK
  } mode_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_ARRAY, OP_IDENT, OP_PGM, OP_ERS, OP_PGM_CHK, OP_ERS_CHK
  } op_e;

  localparam logic [7:0] CODE_RESET  = 8'hFF;
  localparam logic [7:0] CODE_IDENT  = 8'h90;
  localparam logic [7:0] CODE_ERS_GO = 8'h20;
  localparam logic [7:0] MFR_CODE    = 8'h89;
  localparam logic [7:0] DEV_CODE    = 8'hBD;
  localparam logic [7:0] ERASED      = 8'hFF;

  localparam logic [2:0] FN_ARRAY   = 3'b000;
  localparam logic [2:0] FN_ERS     = 3'b001;
  localparam logic [2:0] FN_PGM     = 3'b010;
  localparam logic [2:0] FN_ERS_CHK = 3'b101;
  localparam logic [2:0] FN_PGM_CHK = 3'b110;

  function automatic op_e decode_cmd(input logic [7:0] d);
    op_e op;
    op = OP_NONE;
    if (d == CODE_RESET) op = OP_ARRAY;
    else if (d == CODE_IDENT) op = OP_IDENT;
    else if (d[4:0] == 5'd0) begin
      case (d[7:5])
        FN_ARRAY:   op = OP_ARRAY;
        FN_ERS:     op = OP_ERS;
        FN_PGM:     op = OP_PGM;
        FN_ERS_CHK: op = OP_ERS_CHK;
        FN_PGM_CHK: op = OP_PGM_CHK;
        default:    op = OP_NONE;
      endcase
    end
    return op;
  endfunction
endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  logic          we_q;
  logic          armed_q;
  logic [AW-1:0] addr_q;
  logic          we_fall, we_rise;

  assign we_fall = we_q & ~we_ni;
  assign we_rise = ~we_q & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b1;
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      we_q <= we_ni;
      if (we_fall) begin
        armed_q <= ~cs_ni;
        if (!cs_ni) addr_q <= addr_i;
      end else if (we_rise) begin
        armed_q <= 1'b0;
      end
    end
  end

  // data is taken straight from the pins in the cycle the rising edge is seen
  assign wr_stb_o  = we_rise & armed_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_i;
endmodule

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i) cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          vpp_hi_i,
  input  logic          busy_i,
  output mode_e         mode_o,
  output logic [AW-1:0] chk_addr_o,
  output logic          pgm_o,
  output logic          ers_o
);
  mode_e         mode_q, mode_d;
  logic [AW-1:0] chk_q, chk_d;
  logic          accept;
  op_e           op;

  assign accept = wr_stb_i & vpp_hi_i & ~busy_i;
  assign op     = decode_cmd(wr_data_i);

  always_comb begin
    mode_d = mode_q;
    chk_d  = chk_q;
    pgm_o  = 1'b0;
    ers_o  = 1'b0;
    if (accept) begin
      case (mode_q)
        MODE_PGM_ARM: begin
          pgm_o  = 1'b1;
          mode_d = MODE_ARRAY;
        end
        MODE_ERS_ARM: begin
          ers_o  = (wr_data_i == CODE_ERS_GO);
          mode_d = MODE_ARRAY;
        end
        default: begin
          case (op)
            OP_ARRAY: mode_d = MODE_ARRAY;
            OP_IDENT: mode_d = MODE_IDENT;
            OP_PGM:   mode_d = MODE_PGM_ARM;
            OP_ERS:   mode_d = MODE_ERS_ARM;
            OP_PGM_CHK: begin
              mode_d = MODE_PGM_CHK;
              chk_d  = wr_addr_i;
            end
            OP_ERS_CHK: begin
              mode_d = MODE_ERS_CHK;
              chk_d  = wr_addr_i;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ARRAY;
      chk_q  <= '0;
    end else begin
      mode_q <= mode_d;
      chk_q  <= chk_d;
    end
  end

  assign mode_o     = mode_q;
  assign chk_addr_o = chk_q;
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pgm_i,
  input  logic          ers_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cell_q <= ERASED;
      else if (ers_i) cell_q <= ERASED;
      else if (pgm_i && wr_addr_i == AW'(g)) cell_q <= cell_q & wr_data_i;  // bits only clear
    end
    assign cells[g] = cell_q;
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 4,
  parameter int BUSY_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  logic          vpp_hi_i,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  output logic          busy_o
);
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  mode_e         mode;
  logic [AW-1:0] chk_addr;
  logic          pgm, ers;
  logic [AW-1:0] rd_addr;
  logic [7:0]    cell_rd;

  flash_bus_capture #(.AW(AW)) i_capture (
    .clk_i, .rst_ni, .cs_ni, .we_ni, .addr_i, .data_i,
    .wr_stb_o (wr_stb),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  flash_cmd_fsm #(.AW(AW)) i_fsm (
    .clk_i, .rst_ni,
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .vpp_hi_i,
    .busy_i    (busy_o),
    .mode_o    (mode),
    .chk_addr_o(chk_addr),
    .pgm_o     (pgm),
    .ers_o     (ers)
  );

  flash_busy_timer #(.BUSY_CYC(BUSY_CYC)) i_timer (
    .clk_i, .rst_ni,
    .start_i(pgm | ers),
    .busy_o
  );

  assign rd_addr = (mode == MODE_PGM_CHK || mode == MODE_ERS_CHK) ? chk_addr : addr_i;

  flash_cell_array #(.AW(AW)) i_array (
    .clk_i, .rst_ni,
    .pgm_i    (pgm),
    .ers_i    (ers),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(cell_rd)
  );

  always_comb begin
    if (mode == MODE_IDENT) data_o = addr_i[0] ? DEV_CODE : MFR_CODE;
    else data_o = cell_rd;
  end

  assign data_oe_o = ~cs_ni & ~oe_ni;
endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk
  import flash_cmd_pkg::*;
#(
  parameter int AW       = 4,
  parameter int BUSY_CYC = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic [AW-1:0] addr_i,
  input logic          vpp_hi_i,
  input logic [7:0]    data_o,
  input logic          data_oe_o,
  input logic          busy_o,
  input mode_e         mode_i
);
  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 0;
    else if (busy_o) run_q <= run_q + 1;
    else run_q <= 0;
  end

  AST_STANDBY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);  // R2

  AST_IDENT_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_IDENT && data_oe_o) |-> data_o == (addr_i[0] ? 8'hBD : 8'h89));  // R5

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && run_q != 0) |-> run_q == BUSY_CYC);  // R8

  AST_BUSY_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(mode_i) == MODE_PGM_ARM || $past(mode_i) == MODE_ERS_ARM));  // R9

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(mode_i));  // R10

  AST_NO_VPP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vpp_hi_i && !busy_o) |=> $stable(mode_i));  // R11
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.AW(AW), .BUSY_CYC(BUSY_CYC)) i_chk (
  .clk_i, .rst_ni, .cs_ni, .addr_i, .vpp_hi_i, .data_o, .data_oe_o, .busy_o,
  .mode_i(mode)
);

// File: tb/test_flash_cmd_if.sv
`timescale 1ns/1ps
module test_flash_cmd_if;
  localparam int AW = 4;
  localparam int BUSY_CYC = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, oe_ni = 1'b1, we_ni = 1'b1, vpp_hi_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic [7:0] data_o;
  logic data_oe_o, busy_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.AW(AW), .BUSY_CYC(BUSY_CYC)) i_flash_cmd_if (
    .clk_i(clk), .rst_ni, .cs_ni, .oe_ni, .we_ni, .addr_i, .data_i, .vpp_hi_i,
    .data_o, .data_oe_o, .busy_o
  );

  // reference model: 0 array, 1 ident, 2 pgm armed, 3 erase armed, 4 verify
  logic [7:0] m_mem [DEPTH];
  int m_mode, m_cnt;
  logic [AW-1:0] m_alat, m_vaddr;
  bit m_armed, m_weq;

  task automatic m_apply(input logic [AW-1:0] a, input logic [7:0] d);
    if (m_mode == 2) begin
      m_mem[a] = m_mem[a] & d; m_cnt = BUSY_CYC; m_mode = 0;
    end else if (m_mode == 3) begin
      if (d == 8'h20) begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        m_cnt = BUSY_CYC;
      end
      m_mode = 0;
    end else begin
      case (d)
        8'hFF, 8'h00: m_mode = 0;
        8'h90: m_mode = 1;
        8'h40: m_mode = 2;
        8'h20: m_mode = 3;
        8'hC0, 8'hA0: begin m_mode = 4; m_vaddr = a; end
        default: ;
      endcase
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      m_mode = 0; m_cnt = 0; m_alat = '0; m_vaddr = '0; m_armed = 0; m_weq = 1;
    end else begin
      int busy_now;
      busy_now = m_cnt;
      if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (m_weq && !we_ni) begin m_armed = !cs_ni; m_alat = addr_i; end
      else if (!m_weq && we_ni) begin
        if (m_armed && vpp_hi_i && busy_now == 0) m_apply(m_alat, data_i);
        m_armed = 0;
      end
      m_weq = we_ni;
    end
  end

  function automatic logic [7:0] m_read(input logic [AW-1:0] a);
    if (m_mode == 1) return a[0] ? 8'hBD : 8'h89;
    if (m_mode == 4) return m_mem[m_vaddr];
    return m_mem[a];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_ni && !done) begin
      logic exp_oe;
      exp_oe = !cs_ni && !oe_ni;
      chk(data_oe_o == exp_oe, "R2 drive enable", data_oe_o, exp_oe);
      chk(busy_o == (m_cnt != 0), "R8 busy", busy_o, m_cnt != 0);
      if (exp_oe) chk(data_o == m_read(addr_i), "R4 read data", data_o, m_read(addr_i));
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); cs_ni = 0; we_ni = 0; addr_i = a; data_i = ~d;
    @(negedge clk); we_ni = 1; data_i = d; addr_i = ~a;  // R3: address moves before rise
    @(negedge clk); cs_ni = 1;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); cs_ni = 0; oe_ni = 0; addr_i = a;
    #1;
    chk(data_oe_o === 1'b1, tag, data_oe_o, 1);
    chk(data_o === exp, tag, data_o, exp);
    cs_ni = 1; oe_ni = 1;
  endtask

  task automatic wait_idle();
    repeat (BUSY_CYC + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    @(negedge clk);
    chk(busy_o === 1'b0, "R1 busy after reset", busy_o, 0);
    chk(data_oe_o === 1'b0, "R1 bus idle after reset", data_oe_o, 0);
    for (int i = 0; i < 4; i++) rd_chk(AW'(i), 8'hFF, "R1 erased after reset");

    // R2 output control
    @(negedge clk); cs_ni = 0; oe_ni = 1; #1;
    chk(data_oe_o === 1'b0, "R2 oe high", data_oe_o, 0);
    cs_ni = 1; oe_ni = 0; #1;
    chk(data_oe_o === 1'b0, "R2 standby ignores oe", data_oe_o, 0);
    oe_ni = 1;

    // R11 writes ignored without programming voltage
    bus_wr(0, 8'h90);
    rd_chk(0, 8'hFF, "R11 ident write ignored");
    bus_wr(0, 8'h40); bus_wr(3, 8'h00);
    rd_chk(3, 8'hFF, "R11 program ignored");

    @(negedge clk); vpp_hi_i = 1;
    // R5 identifier
    bus_wr(0, 8'h90);
    rd_chk(0, 8'h89, "R5 manufacturer code");
    rd_chk(1, 8'hBD, "R5 device code");
    // R7 rejected codes
    bus_wr(0, 8'h91);
    rd_chk(1, 8'hBD, "R7 dirty low bits rejected");
    bus_wr(0, 8'h60);
    rd_chk(0, 8'h89, "R7 unassigned code rejected");
    // R6 reset command
    bus_wr(0, 8'hFF);
    rd_chk(0, 8'hFF, "R6 reset to array");

    // R8 program and busy length
    bus_wr(0, 8'h40); bus_wr(5, 8'h3C);
    begin
      int n = 0;
      while (busy_o && n < 100) begin n++; @(negedge clk); end
      chk(n == BUSY_CYC, "R8 busy length", n, BUSY_CYC);
    end
    rd_chk(5, 8'h3C, "R8 programmed byte");
    bus_wr(0, 8'h40); bus_wr(5, 8'hF0); wait_idle();
    rd_chk(5, 8'h30, "R8 program ANDs");

    // R10 writes during busy dropped
    bus_wr(0, 8'h40); bus_wr(6, 8'h0F);
    bus_wr(0, 8'h90);
    wait_idle();
    rd_chk(0, 8'hFF, "R10 write during busy ignored");
    rd_chk(6, 8'h0F, "R4 array read");

    // R12 verify modes
    bus_wr(5, 8'hC0);
    rd_chk(2, 8'h30, "R12 program verify address");
    bus_wr(6, 8'hA0);
    rd_chk(0, 8'h0F, "R12 erase verify address");
    bus_wr(0, 8'h00);
    rd_chk(2, 8'hFF, "R4 back to array read");

    // R9 erase cancel and confirm
    bus_wr(0, 8'h20); bus_wr(0, 8'h55);
    chk(busy_o === 1'b0, "R9 cancel no busy", busy_o, 0);
    rd_chk(5, 8'h30, "R9 cancelled erase");
    bus_wr(0, 8'h20); bus_wr(0, 8'h20);
    chk(busy_o === 1'b1, "R9 erase busy", busy_o, 1);
    wait_idle();
    rd_chk(5, 8'hFF, "R9 erased byte");
    rd_chk(6, 8'hFF, "R9 erased byte");

    // R3 edge capture
    bus_wr(0, 8'h40); bus_wr(9, 8'hA5); wait_idle();
    rd_chk(9, 8'hA5, "R3 address and data edges");
    rd_chk(6, 8'hFF, "R3 late address unused");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule